// File: doc/BRIEF.md
# Hub Status Change Interrupt Reporter

This block produces the answer a hub gives when the host polls its interrupt endpoint for status changes. It keeps every individual change source for the hub itself and for each downstream port. Once per frame, on the late end-of-frame marker, it folds those sources into a one-byte bitmap snapshot. When an IN token for the interrupt endpoint arrives, it registers a handshake choice (NAK, data or STALL) and, for data, the snapshot byte. Serialization of the packet happens elsewhere.

Alongside the bitmap it holds a four-bit controller status register. The register covers configuration, remote wakeup enable and the halt state of the control and interrupt endpoints. It is driven by decoded set-configuration and set/clear-feature request strobes. Clear-feature requests for individual change sources arrive as a unit number and a source index.

Top module: `hub_chg_reporter`

## Requirements
- R1: The bitmap snapshot changes only in a cycle where `eof_mark_i` is high. At that edge it takes the change sources as they stood before the edge, so a source raised after the last marker is not reported.
- R2: Snapshot bit 0 is the OR of the hub change sources and bit p (1..4) is the OR of port p's sources. Bits 5 to 7 are always zero. A data response returns the whole snapshot byte on `data_o`.
- R3: An IN token while configured and not halted, with a zero snapshot, yields NAK (`hs_o` = 1).
- R4: While the configured bit is clear, every IN token yields NAK unless the interrupt endpoint is halted.
- R5: A change source stays set until a clear request names that unit (0 = hub, p = port p) and that source index. A port's bitmap bit stays set while any of its sources remains. An event and a clear of the same source in one cycle leave it set.
- R6: When the interrupt-endpoint halt bit is set, an IN token yields STALL (`hs_o` = 3) with `data_o` = 0, ahead of NAK and data.
- R7: The response appears in the cycle after the token and lasts one cycle. With no token `hs_o` = 0 and `data_o` = 0. A data response is `hs_o` = 2.
- R8: `ctrl_stat_o` is bit 0 configured, bit 1 remote wakeup enabled, bit 2 control endpoint halted, bit 3 interrupt endpoint halted, and it resets to 0. A set-configuration request writes bit 0 from `cfg_val_i`. A feature request writes `feat_set_i` into bit 1, 2 or 3 for selector 0, 1 or 2, and selector 3 changes nothing.
- R9: A clear request whose unit number exceeds the port count, or whose source index exceeds that unit's source count, changes no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hub_evt_i | input | 2 | Pulses raising hub-level change sources |
| port_evt_i | input | 20 | Pulses raising port change sources, port p source s at bit (p-1)*5+s |
| clr_req_i | input | 1 | Clear-feature strobe for one change source |
| clr_unit_i | input | 3 | Unit of the clear: 0 hub, 1..4 port |
| clr_src_i | input | 3 | Source index within the unit |
| eof_mark_i | input | 1 | Late end-of-frame marker strobe |
| in_tok_i | input | 1 | IN token for the interrupt endpoint |
| set_cfg_i | input | 1 | Set-configuration request strobe |
| cfg_val_i | input | 1 | Configuration value is nonzero |
| feat_req_i | input | 1 | Set/clear-feature request strobe |
| feat_set_i | input | 1 | 1 = set feature, 0 = clear feature |
| feat_sel_i | input | 2 | Feature selector: 0 wakeup, 1 control halt, 2 interrupt halt |
| hs_o | output | 2 | Handshake: 0 none, 1 NAK, 2 data, 3 STALL |
| data_o | output | 8 | Bitmap byte for a data response |
| ctrl_stat_o | output | 4 | Controller status register |

## Verification
The assertions assume that the request strobes are decoded upstream. At most one set-configuration and one feature request arrive per cycle, and each is a single-cycle pulse. They also assume that the source event pulses are already synchronous to `clk`. The stimulus drives every input at the falling edge from a seeded generator, so each value is stable across the rising edge. Clear requests are drawn over the full unit and source ranges, so illegal indices occur. Markers and tokens fall in the same cycles as events and clears often enough to reach the same-edge orderings.

// File: rtl/hscr_pkg.sv
package hscr_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_NAK   = 2'd1,
    HS_DATA  = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  localparam int STAT_W = 4;
  localparam int ST_CFG = 0;
  localparam int ST_RWU = 1;
  localparam int ST_H0  = 2;
  localparam int ST_H1  = 3;
endpackage

// File: rtl/hscr_src_bank.sv
module hscr_src_bank #(
  parameter int NSRC = 5,
  parameter int SW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_hit_i,
  input  logic [SW-1:0]   clr_src_i,
  output logic            any_o
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] clr_mask;

  for (genvar i = 0; i < NSRC; i++) begin : g_mask
    assign clr_mask[i] = clr_hit_i && (clr_src_i == SW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= (src_q & ~clr_mask) | evt_i;
  end

  assign any_o = |src_q;

  // R5: a raised source is held on the next cycle, even against a clear
  a_r5_evt_held: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((($past(evt_i)) & ~src_q) == '0));
  // R5: a source with no clear aimed at it never drops
  a_r5_no_spont_drop: assert property (@(posedge clk) disable iff (rst)
    (!clr_hit_i && any_o) |=> any_o);
endmodule

// File: rtl/hscr_ctrl_status.sv
module hscr_ctrl_status
  import hscr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_cfg_i,
  input  logic              cfg_val_i,
  input  logic              feat_req_i,
  input  logic              feat_set_i,
  input  logic [1:0]        feat_sel_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      if (set_cfg_i) stat_q[ST_CFG] <= cfg_val_i;
      if (feat_req_i) begin
        case (feat_sel_i)
          2'd0:    stat_q[ST_RWU] <= feat_set_i;
          2'd1:    stat_q[ST_H0]  <= feat_set_i;
          2'd2:    stat_q[ST_H1]  <= feat_set_i;
          default: ;
        endcase
      end
    end
  end

  assign stat_o = stat_q;

  // R8: set-configuration lands in bit 0 one cycle later
  a_r8_cfg_write: assert property (@(posedge clk) disable iff (rst)
    set_cfg_i |=> (stat_o[ST_CFG] == $past(cfg_val_i)));
  // R8: selector 3 leaves the register untouched
  a_r8_sel3_noop: assert property (@(posedge clk) disable iff (rst)
    (feat_req_i && feat_sel_i == 2'd3 && !set_cfg_i) |=> $stable(stat_o));
endmodule

// File: rtl/hscr_responder.sv
module hscr_responder
  import hscr_pkg::*;
#(
  parameter int NUNIT = 5,
  parameter int MAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUNIT-1:0] live_i,
  input  logic             eof_i,
  input  logic             in_tok_i,
  input  logic             cfg_i,
  input  logic             halt_i,
  output logic [1:0]       hs_o,
  output logic [MAP_W-1:0] data_o
);
  logic [MAP_W-1:0] snap_q;
  hs_e              hs_q;
  logic [MAP_W-1:0] data_q;
  hs_e              hs_d;

  always_ff @(posedge clk) begin
    if (rst)        snap_q <= '0;
    else if (eof_i) snap_q <= MAP_W'(live_i);
  end

  always_comb begin
    if (!in_tok_i)                    hs_d = HS_NONE;
    else if (halt_i)                  hs_d = HS_STALL;
    else if (!cfg_i || snap_q == '0)  hs_d = HS_NAK;
    else                              hs_d = HS_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q   <= HS_NONE;
      data_q <= '0;
    end else begin
      hs_q   <= hs_d;
      data_q <= (hs_d == HS_DATA) ? snap_q : '0;
    end
  end

  assign hs_o   = hs_q;
  assign data_o = data_q;

  // R1: the snapshot moves only on a marker
  a_r1_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !eof_i |=> $stable(snap_q));
  // R6: halt wins over every other answer
  a_r6_stall_first: assert property (@(posedge clk) disable iff (rst)
    (in_tok_i && halt_i) |=> (hs_o == HS_STALL && data_o == '0));
  // R4: unconfigured and not halted answers NAK
  a_r4_unconf_nak: assert property (@(posedge clk) disable iff (rst)
    (in_tok_i && !halt_i && !cfg_i) |=> (hs_o == HS_NAK));
  // R7: idle outside the cycle after a token
  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    !in_tok_i |=> (hs_o == HS_NONE && data_o == '0));
  // R2: a data answer carries a nonzero byte
  a_r2_data_nonzero: assert property (@(posedge clk) disable iff (rst)
    (hs_o == HS_DATA) |-> (data_o != '0));
  if (MAP_W > NUNIT) begin : g_rsv
    // R2: reserved bits stay zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      data_o[MAP_W-1:NUNIT] == '0);
  end
endmodule

// File: rtl/hub_chg_reporter.sv
module hub_chg_reporter
  import hscr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int HUB_SRC   = 2,
  parameter int PORT_SRC  = 5,
  localparam int NUNIT    = NUM_PORTS + 1,
  localparam int UNIT_W   = $clog2(NUNIT),
  localparam int MAX_SRC  = (HUB_SRC > PORT_SRC) ? HUB_SRC : PORT_SRC,
  localparam int SRC_W    = (MAX_SRC > 1) ? $clog2(MAX_SRC) : 1,
  localparam int MAP_W    = ((NUNIT + 7) / 8) * 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [HUB_SRC-1:0]            hub_evt_i,
  input  logic [NUM_PORTS*PORT_SRC-1:0] port_evt_i,
  input  logic                          clr_req_i,
  input  logic [UNIT_W-1:0]             clr_unit_i,
  input  logic [SRC_W-1:0]              clr_src_i,
  input  logic                          eof_mark_i,
  input  logic                          in_tok_i,
  input  logic                          set_cfg_i,
  input  logic                          cfg_val_i,
  input  logic                          feat_req_i,
  input  logic                          feat_set_i,
  input  logic [1:0]                    feat_sel_i,
  output logic [1:0]                    hs_o,
  output logic [MAP_W-1:0]              data_o,
  output logic [STAT_W-1:0]             ctrl_stat_o
);
  logic [NUNIT-1:0] live;

  hscr_src_bank #(.NSRC(HUB_SRC), .SW(SRC_W)) u_hub_bank (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (hub_evt_i),
    .clr_hit_i (clr_req_i && clr_unit_i == '0),
    .clr_src_i (clr_src_i),
    .any_o     (live[0])
  );

  for (genvar p = 1; p <= NUM_PORTS; p++) begin : g_port
    hscr_src_bank #(.NSRC(PORT_SRC), .SW(SRC_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .evt_i     (port_evt_i[(p-1)*PORT_SRC +: PORT_SRC]),
      .clr_hit_i (clr_req_i && clr_unit_i == UNIT_W'(p)),
      .clr_src_i (clr_src_i),
      .any_o     (live[p])
    );
  end

  hscr_ctrl_status u_stat (
    .clk        (clk),
    .rst        (rst),
    .set_cfg_i  (set_cfg_i),
    .cfg_val_i  (cfg_val_i),
    .feat_req_i (feat_req_i),
    .feat_set_i (feat_set_i),
    .feat_sel_i (feat_sel_i),
    .stat_o     (ctrl_stat_o)
  );

  hscr_responder #(.NUNIT(NUNIT), .MAP_W(MAP_W)) u_resp (
    .clk      (clk),
    .rst      (rst),
    .live_i   (live),
    .eof_i    (eof_mark_i),
    .in_tok_i (in_tok_i),
    .cfg_i    (ctrl_stat_o[ST_CFG]),
    .halt_i   (ctrl_stat_o[ST_H1]),
    .hs_o     (hs_o),
    .data_o   (data_o)
  );
endmodule

// File: tb/hub_chg_reporter_test.sv
module hub_chg_reporter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  hub_evt;
  logic [19:0] port_evt;
  logic        clr_req;
  logic [2:0]  clr_unit, clr_src;
  logic        eof, in_tok, set_cfg, cfg_val, feat_req, feat_set;
  logic [1:0]  feat_sel;
  logic [1:0]  hs;
  logic [7:0]  data;
  logic [3:0]  stat;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [1:0]  m_hub;
  logic [19:0] m_port;
  logic [7:0]  m_snap;
  logic [3:0]  m_stat;

  always #5 clk = ~clk;

  hub_chg_reporter uut (
    .clk(clk), .rst(rst), .hub_evt_i(hub_evt), .port_evt_i(port_evt),
    .clr_req_i(clr_req), .clr_unit_i(clr_unit), .clr_src_i(clr_src),
    .eof_mark_i(eof), .in_tok_i(in_tok), .set_cfg_i(set_cfg),
    .cfg_val_i(cfg_val), .feat_req_i(feat_req), .feat_set_i(feat_set),
    .feat_sel_i(feat_sel), .hs_o(hs), .data_o(data), .ctrl_stat_o(stat)
  );

  function automatic logic [7:0] live_map(logic [1:0] h, logic [19:0] p);
    logic [7:0] m = '0;
    m[0] = |h;
    for (int k = 1; k <= 4; k++) m[k] = |p[(k-1)*5 +: 5];
    return m;
  endfunction

  task automatic idle();
    hub_evt = '0; port_evt = '0; clr_req = 0; clr_unit = '0; clr_src = '0;
    eof = 0; in_tok = 0; set_cfg = 0; cfg_val = 0; feat_req = 0;
    feat_set = 0; feat_sel = '0;
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: inputs already set; model predicts, outputs compared after edge
  task automatic cyc(string tag);
    logic [1:0] e_hs;
    logic [7:0] e_data;
    logic [1:0] n_hub;
    logic [19:0] n_port;
    string t;
    if (!in_tok)                          begin e_hs = 0; t = "R7"; end
    else if (m_stat[3])                   begin e_hs = 3; t = "R6"; end
    else if (!m_stat[0])                  begin e_hs = 1; t = "R4"; end
    else if (m_snap == 0)                 begin e_hs = 1; t = "R3"; end
    else                                  begin e_hs = 2; t = "R2"; end
    e_data = (e_hs == 2) ? m_snap : 8'h00;
    if (tag != "") t = tag;
    n_hub  = m_hub;
    n_port = m_port;
    if (clr_req && clr_unit == 0 && clr_src < 2) n_hub[clr_src] = 1'b0;
    if (clr_req && clr_unit >= 1 && clr_unit <= 4 && clr_src < 5)
      n_port[(clr_unit-1)*5 + clr_src] = 1'b0;
    n_hub  = n_hub | hub_evt;
    n_port = n_port | port_evt;
    if (eof) m_snap = live_map(m_hub, m_port);
    m_hub  = n_hub;
    m_port = n_port;
    if (set_cfg) m_stat[0] = cfg_val;
    if (feat_req && feat_sel != 3) m_stat[feat_sel + 1] = feat_set;
    @(posedge clk);
    @(negedge clk);
    check(t, {6'd0, hs, data}, {6'd0, e_hs, e_data});
    check("R8", {12'd0, stat}, {12'd0, m_stat});
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    m_hub = '0; m_port = '0; m_snap = '0; m_stat = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R8: reset state
    check("R8", {6'd0, hs, data, stat}, 16'h0);

    set_cfg = 1; cfg_val = 1; cyc("R8");
    in_tok = 1; cyc("R3");
    port_evt = 20'(1) << 8; cyc("R5");       // port 2 source 3
    in_tok = 1; cyc("R1");                   // not yet sampled
    eof = 1; port_evt = 20'(1) << 13; cyc("R1"); // port 3 raised on the marker edge
    in_tok = 1; cyc("R2");                   // 0x04 only
    clr_req = 1; clr_unit = 3; clr_src = 3; cyc("R5");
    port_evt = 20'(1) << 6; cyc("R5");       // port 2 source 1
    eof = 1; cyc("R1");
    clr_req = 1; clr_unit = 2; clr_src = 3; cyc("R5");
    eof = 1; cyc("R5");
    in_tok = 1; cyc("R5");                   // still 0x04 via source 1
    clr_req = 1; clr_unit = 5; clr_src = 1; cyc("R9");
    clr_req = 1; clr_unit = 2; clr_src = 6; cyc("R9");
    eof = 1; cyc("R9");
    in_tok = 1; cyc("R9");
    clr_req = 1; clr_unit = 2; clr_src = 1; port_evt = 20'(1) << 6; cyc("R5");
    eof = 1; cyc("R5");
    in_tok = 1; cyc("R5");                   // event beat clear
    clr_req = 1; clr_unit = 2; clr_src = 1; cyc("R5");
    eof = 1; cyc("R5");
    in_tok = 1; cyc("R5");                   // now NAK
    hub_evt = 2'b10; eof = 1; cyc("R2");
    eof = 1; cyc("R2");
    in_tok = 1; cyc("R2");
    feat_req = 1; feat_set = 1; feat_sel = 2; cyc("R8");
    in_tok = 1; cyc("R6");
    feat_req = 1; feat_set = 0; feat_sel = 2; cyc("R8");
    feat_req = 1; feat_set = 1; feat_sel = 3; cyc("R8");
    set_cfg = 1; cfg_val = 0; cyc("R8");
    in_tok = 1; cyc("R4");

    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < 2; b++)  hub_evt[b]  = ($urandom % 24) == 0;
      for (int b = 0; b < 20; b++) port_evt[b] = ($urandom % 40) == 0;
      clr_req  = ($urandom % 3) == 0;
      clr_unit = 3'($urandom);
      clr_src  = 3'($urandom);
      eof      = ($urandom % 6) == 0;
      in_tok   = ($urandom % 3) == 0;
      set_cfg  = ($urandom % 30) == 0;
      cfg_val  = ($urandom % 4) != 0;
      feat_req = ($urandom % 20) == 0;
      feat_set = ($urandom % 3) == 0;
      feat_sel = 2'($urandom);
      cyc("");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule